// File: doc/BRIEF.md
# Card host controller register front end

This block is the software-visible register layer of a memory-card host controller. It sits behind a simple single-cycle strobe bus covering a 4 KB window of 32-bit words. It holds the control registers that the command and data engines read: power, clock divider, command argument, command word, data timer, data length and data control. It also shows the values those engines report back: the response command, four response words and the remaining byte count. Two one-cycle start pulses go out, one for the command engine and one for the data engine.

Completion and error events reach the block as one-cycle set pulses. They collect in a sticky status word that software clears by writing ones to a separate clear register. Only the low eleven event bits can be cleared this way. Two independent mask registers each select a subset of the status word, and each drives its own level interrupt line. A sixteen-word window forwards reads and writes to the transmit/receive FIFO that lives in the datapath. A short identification area sits at the top of the map.

Top module: `card_regs`

## Requirements
- R1: While reset is asserted, every stored register, the status word, both masks, both interrupt lines and both start pulses are zero.
- R2: Byte offsets 0x00 (power), 0x04 (clock) and 0x2C (data control) keep bits [7:0] of a write. Offset 0x28 (data length) keeps bits [15:0]. Offsets 0x08 (argument) and 0x24 (data timer) keep all 32 bits. Each reads back at its own offset and appears on its own output port.
- R3: A write to 0x0C with bit 10 set raises cmd_go for exactly the cycle after the write, and the stored command (port and readback) has bit 10 cleared. A write to 0x2C with bit 0 set raises data_go for the cycle after the write.
- R4: Status (read at 0x34, 22 bits, zero-extended) is sticky. A bit set by sts_set stays set until a clear write removes it. A bit that is set and cleared in the same cycle ends up set.
- R5: A write to 0x38 clears each status bit in [10:0] whose written bit is 1. Status bits [21:11] are never cleared by it. A read of 0x38 returns zero.
- R6: irq[n] is high in the cycle after the cycle where status AND mask n is non-zero. Mask 0 sits at 0x3C and mask 1 at 0x40, and each is read/write with all 32 bits.
- R7: A read of any word from 0x80 to 0xBC with the FIFO non-empty asserts fifo_pop for that cycle and returns fifo_rdata. With the FIFO empty it returns zero and does not pop.
- R8: A write to any word from 0x80 to 0xBC asserts fifo_push with fifo_wdata equal to the written word, but only while byte_cnt is non-zero.
- R9: Reads of 0xFE0 through 0xFFC return, one byte per word in rising address order, 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of unmapped offsets (for example 0x44, 0x4C, 0x7C, 0xC0, 0xFDC) return zero. Writes to them, and to the read-only offsets, change no register, status bit or output.
- R11: 0x10 returns resp_cmd_in. 0x14+4n returns resp_in[32n+31:32n] for n = 0..3. 0x30 returns byte_cnt. 0x48 returns byte_cnt divided by four, rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| sts_set | input | 22 | One-cycle status set pulses from the engines |
| resp_cmd_in | input | 32 | Response command index from the command engine |
| resp_in | input | 128 | Four response words, word n in bits [32n+31:32n] |
| byte_cnt | input | 16 | Remaining data byte count from the data engine |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Remove the head word this cycle |
| fifo_push | output | 1 | Append fifo_wdata this cycle |
| fifo_wdata | output | 32 | Word to append |
| pwr_q | output | 8 | Power register |
| clkdiv_q | output | 8 | Clock register |
| arg_q | output | 32 | Command argument |
| cmd_q | output | 32 | Command word, start bit cleared |
| dtmr_q | output | 32 | Data timer |
| dlen_q | output | 16 | Data length |
| dctl_q | output | 8 | Data control |
| cmd_go | output | 1 | Command start pulse |
| data_go | output | 1 | Data start pulse |
| irq | output | 2 | Masked interrupt lines |

## Verification
The hardest case to reach is the one where an engine sets a status bit in the same cycle as software clears it. The stimulus lines up an sts_set pulse with a write to the clear offset. It also sets bits above bit 10 before writing all ones there, to show that the upper bits survive. FIFO behaviour is reached without a preloaded FIFO. The bench acts as the FIFO, fills it through window writes while byte_cnt is non-zero, and then drains it past empty through addresses spread across the window. A behavioural model, updated on every clock, predicts the interrupt lines one cycle late, so a line that drops or rises a cycle early is caught.

// File: rtl/card_regs_pkg.sv
package card_regs_pkg;

   // Which register an address selects.
   typedef enum logic [4:0] {
      RG_NONE, RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_RCMD, RG_RSP, RG_DTMR,
      RG_DLEN, RG_DCTL, RG_DCNT, RG_STAT, RG_CLR, RG_MSK, RG_FCNT,
      RG_FIFO, RG_ID
   } reg_sel_e;

   // Word indices (byte offset / 4) of the map.
   localparam int WI_PWR     = 0;
   localparam int WI_CLK     = 1;
   localparam int WI_ARG     = 2;
   localparam int WI_CMD     = 3;
   localparam int WI_RCMD    = 4;
   localparam int WI_RSP_LO  = 5;
   localparam int WI_RSP_HI  = 8;
   localparam int WI_DTMR    = 9;
   localparam int WI_DLEN    = 10;
   localparam int WI_DCTL    = 11;
   localparam int WI_DCNT    = 12;
   localparam int WI_STAT    = 13;
   localparam int WI_CLR     = 14;
   localparam int WI_MSK_LO  = 15;
   localparam int WI_MSK_HI  = 16;
   localparam int WI_FCNT    = 18;
   localparam int WI_FIFO_LO = 32;
   localparam int WI_FIFO_HI = 47;
   localparam int WI_ID_LO   = 1016;
   localparam int WI_ID_HI   = 1023;

   localparam int CMD_GO_BIT  = 10;
   localparam int DATA_GO_BIT = 0;

   function automatic logic [7:0] id_byte(input logic [2:0] idx);
      case (idx)
         3'd0: id_byte = 8'h81;
         3'd1: id_byte = 8'h11;
         3'd2: id_byte = 8'h04;
         3'd3: id_byte = 8'h00;
         3'd4: id_byte = 8'h0D;
         3'd5: id_byte = 8'hF0;
         3'd6: id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction

endpackage

// File: rtl/card_regs_decode.sv
module card_regs_decode
   import card_regs_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-3:0] word_addr,
   output reg_sel_e          sel,
   output logic [2:0]        sub
);
   localparam int WA_W = ADDR_W - 2;
   typedef logic [WA_W-1:0] wa_t;

   always_comb begin
      sel = RG_NONE;
      sub = '0;
      if (word_addr >= wa_t'(WI_FIFO_LO) && word_addr <= wa_t'(WI_FIFO_HI)) begin
         sel = RG_FIFO;
      end else if (word_addr >= wa_t'(WI_ID_LO) && word_addr <= wa_t'(WI_ID_HI)) begin
         sel = RG_ID;
         sub = 3'(word_addr - wa_t'(WI_ID_LO));
      end else if (word_addr >= wa_t'(WI_RSP_LO) && word_addr <= wa_t'(WI_RSP_HI)) begin
         sel = RG_RSP;
         sub = 3'(word_addr - wa_t'(WI_RSP_LO));
      end else if (word_addr >= wa_t'(WI_MSK_LO) && word_addr <= wa_t'(WI_MSK_HI)) begin
         sel = RG_MSK;
         sub = 3'(word_addr - wa_t'(WI_MSK_LO));
      end else begin
         case (word_addr)
            wa_t'(WI_PWR):  sel = RG_PWR;
            wa_t'(WI_CLK):  sel = RG_CLK;
            wa_t'(WI_ARG):  sel = RG_ARG;
            wa_t'(WI_CMD):  sel = RG_CMD;
            wa_t'(WI_RCMD): sel = RG_RCMD;
            wa_t'(WI_DTMR): sel = RG_DTMR;
            wa_t'(WI_DLEN): sel = RG_DLEN;
            wa_t'(WI_DCTL): sel = RG_DCTL;
            wa_t'(WI_DCNT): sel = RG_DCNT;
            wa_t'(WI_STAT): sel = RG_STAT;
            wa_t'(WI_CLR):  sel = RG_CLR;
            wa_t'(WI_FCNT): sel = RG_FCNT;
            default:        sel = RG_NONE;
         endcase
      end
   end
endmodule

// File: rtl/card_regs_ctrl.sv
module card_regs_ctrl
   import card_regs_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 8,
   parameter int LEN_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  reg_sel_e            sel,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NARROW_W-1:0] pwr_q,
   output logic [NARROW_W-1:0] clkdiv_q,
   output logic [DATA_W-1:0]   arg_q,
   output logic [DATA_W-1:0]   cmd_q,
   output logic [DATA_W-1:0]   dtmr_q,
   output logic [LEN_W-1:0]    dlen_q,
   output logic [NARROW_W-1:0] dctl_q,
   output logic                cmd_go,
   output logic                data_go
);
   localparam logic [DATA_W-1:0] GO_CLR = ~(DATA_W'(1) << CMD_GO_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q    <= '0;
         clkdiv_q <= '0;
         arg_q    <= '0;
         cmd_q    <= '0;
         dtmr_q   <= '0;
         dlen_q   <= '0;
         dctl_q   <= '0;
         cmd_go   <= 1'b0;
         data_go  <= 1'b0;
      end else begin
         cmd_go  <= 1'b0;
         data_go <= 1'b0;
         if (wr_en) begin
            case (sel)
               RG_PWR:  pwr_q    <= wdata[NARROW_W-1:0];
               RG_CLK:  clkdiv_q <= wdata[NARROW_W-1:0];
               RG_ARG:  arg_q    <= wdata;
               RG_CMD: begin
                  cmd_q  <= wdata & GO_CLR;
                  cmd_go <= wdata[CMD_GO_BIT];
               end
               RG_DTMR: dtmr_q <= wdata;
               RG_DLEN: dlen_q <= wdata[LEN_W-1:0];
               RG_DCTL: begin
                  dctl_q  <= wdata[NARROW_W-1:0];
                  data_go <= wdata[DATA_GO_BIT];
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/card_regs_status.sv
module card_regs_status #(
   parameter int STAT_W  = 22,
   parameter int CLR_W   = 11,
   parameter int DATA_W  = 32,
   parameter int NUM_IRQ = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [STAT_W-1:0]         set_in,
   input  logic                      clr_wr,
   input  logic                      msk_wr,
   input  logic [2:0]                msk_idx,
   input  logic [DATA_W-1:0]         wdata,
   output logic [STAT_W-1:0]         sts_q,
   output logic [NUM_IRQ*DATA_W-1:0] msk_flat,
   output logic [NUM_IRQ-1:0]        irq
);
   localparam logic [STAT_W-1:0] CLR_MASK = STAT_W'((64'd1 << CLR_W) - 64'd1);

   logic [STAT_W-1:0] clr_bits;
   assign clr_bits = clr_wr ? (wdata[STAT_W-1:0] & CLR_MASK) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_bits) | set_in;
   end

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
      logic [DATA_W-1:0] m_q;
      logic              i_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= '0;
            i_q <= 1'b0;
         end else begin
            if (msk_wr && int'(msk_idx) == n) m_q <= wdata;
            i_q <= |(sts_q & m_q[STAT_W-1:0]);
         end
      end
      assign msk_flat[n*DATA_W +: DATA_W] = m_q;
      assign irq[n] = i_q;
   end
endmodule

// File: rtl/card_regs.sv
module card_regs
   import card_regs_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 8,
   parameter int LEN_W    = 16,
   parameter int STAT_W   = 22,
   parameter int CLR_W    = 11,
   parameter int NUM_IRQ  = 2,
   parameter int NUM_RSP  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [STAT_W-1:0]       sts_set,
   input  logic [DATA_W-1:0]       resp_cmd_in,
   input  logic [NUM_RSP*DATA_W-1:0] resp_in,
   input  logic [LEN_W-1:0]        byte_cnt,
   input  logic [DATA_W-1:0]       fifo_rdata,
   input  logic                    fifo_empty,
   output logic                    fifo_pop,
   output logic                    fifo_push,
   output logic [DATA_W-1:0]       fifo_wdata,
   output logic [NARROW_W-1:0]     pwr_q,
   output logic [NARROW_W-1:0]     clkdiv_q,
   output logic [DATA_W-1:0]       arg_q,
   output logic [DATA_W-1:0]       cmd_q,
   output logic [DATA_W-1:0]       dtmr_q,
   output logic [LEN_W-1:0]        dlen_q,
   output logic [NARROW_W-1:0]     dctl_q,
   output logic                    cmd_go,
   output logic                    data_go,
   output logic [NUM_IRQ-1:0]      irq
);
   localparam int FC_W = LEN_W + 2;

   // Elaboration-time parameter checks.
   if (ADDR_W < 12) begin : g_bad_addr
      $error("card_regs: ADDR_W must cover the 4 KB map");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 2) begin : g_bad_irq
      $error("card_regs: the map has two mask slots");
   end
   if (NUM_RSP != 4) begin : g_bad_rsp
      $error("card_regs: the map has four response slots");
   end
   if (CLR_W > STAT_W || STAT_W > DATA_W) begin : g_bad_stat
      $error("card_regs: CLR_W <= STAT_W <= DATA_W required");
   end
   if (NARROW_W > DATA_W || LEN_W + 2 > DATA_W) begin : g_bad_narrow
      $error("card_regs: register widths exceed the data bus");
   end

   reg_sel_e          sel;
   logic [2:0]        sub;
   logic [1:0]        addr_unused;
   logic              wr_en;
   logic              rd_en;
   logic              clr_wr;
   logic              msk_wr;
   logic [STAT_W-1:0] sts_q;
   logic [NUM_IRQ*DATA_W-1:0] msk_flat;
   logic [FC_W-1:0]   fcnt_w;

   assign addr_unused = bus_addr[1:0];
   assign wr_en  = bus_sel &  bus_wr;
   assign rd_en  = bus_sel & ~bus_wr;
   assign clr_wr = wr_en && sel == RG_CLR;
   assign msk_wr = wr_en && sel == RG_MSK;

   card_regs_decode #(.ADDR_W(ADDR_W)) u_dec (
      .word_addr (bus_addr[ADDR_W-1:2]),
      .sel       (sel),
      .sub       (sub)
   );

   card_regs_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .LEN_W(LEN_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .wr_en    (wr_en),
      .wdata    (bus_wdata),
      .pwr_q    (pwr_q),
      .clkdiv_q (clkdiv_q),
      .arg_q    (arg_q),
      .cmd_q    (cmd_q),
      .dtmr_q   (dtmr_q),
      .dlen_q   (dlen_q),
      .dctl_q   (dctl_q),
      .cmd_go   (cmd_go),
      .data_go  (data_go)
   );

   card_regs_status #(.STAT_W(STAT_W), .CLR_W(CLR_W), .DATA_W(DATA_W),
                      .NUM_IRQ(NUM_IRQ)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_in   (sts_set),
      .clr_wr   (clr_wr),
      .msk_wr   (msk_wr),
      .msk_idx  (sub),
      .wdata    (bus_wdata),
      .sts_q    (sts_q),
      .msk_flat (msk_flat),
      .irq      (irq)
   );

   // FIFO window routing.
   assign fifo_pop   = rd_en && sel == RG_FIFO && !fifo_empty;
   assign fifo_push  = wr_en && sel == RG_FIFO && byte_cnt != '0;
   assign fifo_wdata = bus_wdata;

   assign fcnt_w = ({2'b00, byte_cnt} + FC_W'(3)) >> 2;

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         case (sel)
            RG_PWR:  bus_rdata = DATA_W'(pwr_q);
            RG_CLK:  bus_rdata = DATA_W'(clkdiv_q);
            RG_ARG:  bus_rdata = arg_q;
            RG_CMD:  bus_rdata = cmd_q;
            RG_RCMD: bus_rdata = resp_cmd_in;
            RG_RSP:  bus_rdata = resp_in[DATA_W*int'(sub[1:0]) +: DATA_W];
            RG_DTMR: bus_rdata = dtmr_q;
            RG_DLEN: bus_rdata = DATA_W'(dlen_q);
            RG_DCTL: bus_rdata = DATA_W'(dctl_q);
            RG_DCNT: bus_rdata = DATA_W'(byte_cnt);
            RG_STAT: bus_rdata = DATA_W'(sts_q);
            RG_MSK:  bus_rdata = (int'(sub[0]) < NUM_IRQ) ?
                                 msk_flat[DATA_W*int'(sub[0]) +: DATA_W] : '0;
            RG_FCNT: bus_rdata = DATA_W'(fcnt_w);
            RG_FIFO: bus_rdata = fifo_empty ? '0 : fifo_rdata;
            RG_ID:   bus_rdata = DATA_W'(id_byte(sub));
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/card_regs_chk.sv
module card_regs_chk #(
   parameter int STAT_W  = 22,
   parameter int CLR_W   = 11,
   parameter int DATA_W  = 32,
   parameter int NUM_IRQ = 2,
   parameter int LEN_W   = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [STAT_W-1:0]         sts_q,
   input logic [NUM_IRQ*DATA_W-1:0] msk_flat,
   input logic [NUM_IRQ-1:0]        irq,
   input logic                      clr_wr,
   input logic                      fifo_pop,
   input logic                      fifo_empty,
   input logic                      fifo_push,
   input logic [LEN_W-1:0]          byte_cnt
);
   localparam logic [STAT_W-1:0] HIGH_BITS = ~STAT_W'((64'd1 << CLR_W) - 64'd1);

   for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
      // R6: a line follows its masked status one cycle later
      a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (|(sts_q & msk_flat[n*DATA_W +: STAT_W])) |=> irq[n]);
      a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(sts_q & msk_flat[n*DATA_W +: STAT_W])) |=> !irq[n]);
   end

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (($past(sts_q) & ~sts_q) == STAT_W'(0)));

   a_r5_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(sts_q) & ~sts_q & HIGH_BITS) == STAT_W'(0)));

   a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);

   a_r8_push_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (byte_cnt != LEN_W'(0)));
endmodule

bind card_regs card_regs_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sts_q      (sts_q),
   .msk_flat   (msk_flat),
   .irq        (irq),
   .clr_wr     (clr_wr),
   .fifo_pop   (fifo_pop),
   .fifo_empty (fifo_empty),
   .fifo_push  (fifo_push),
   .byte_cnt   (byte_cnt)
);

// File: tb/card_regs_bench.sv
`timescale 1ns/1ps
module card_regs_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [21:0]  sts_set = '0;
   logic [31:0]  resp_cmd_in = 32'h0000_0029;
   logic [127:0] resp_in = 128'hD4D4_0004_C3C3_0003_B2B2_0002_A1A1_0001;
   logic [15:0]  byte_cnt = '0;
   logic [31:0]  fifo_rdata = '0;
   logic         fifo_empty = 1'b1;
   logic         fifo_pop, fifo_push;
   logic [31:0]  fifo_wdata;
   logic [7:0]   pwr_q, clkdiv_q, dctl_q;
   logic [31:0]  arg_q, cmd_q, dtmr_q;
   logic [15:0]  dlen_q;
   logic         cmd_go, data_go;
   logic [1:0]   irq;

   always #5 clk = ~clk;

   card_regs u_card_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sts_set(sts_set), .resp_cmd_in(resp_cmd_in), .resp_in(resp_in),
      .byte_cnt(byte_cnt), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
      .pwr_q(pwr_q), .clkdiv_q(clkdiv_q), .arg_q(arg_q), .cmd_q(cmd_q),
      .dtmr_q(dtmr_q), .dlen_q(dlen_q), .dctl_q(dctl_q),
      .cmd_go(cmd_go), .data_go(data_go), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   // Behavioural reference state.
   logic [7:0]  m_pwr = '0, m_clk = '0, m_dctl = '0;
   logic [31:0] m_arg = '0, m_cmd = '0, m_dtmr = '0;
   logic [15:0] m_dlen = '0;
   logic [21:0] m_sts = '0;
   logic [21:0] m_clr;
   logic [31:0] m_msk0 = '0, m_msk1 = '0;
   logic [1:0]  m_irq = '0;
   logic        m_cmdgo = 1'b0, m_datago = 1'b0;
   logic [31:0] fq[$];
   logic [7:0]  id_tab [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pwr = '0; m_clk = '0; m_dctl = '0; m_arg = '0; m_cmd = '0;
         m_dtmr = '0; m_dlen = '0; m_sts = '0; m_msk0 = '0; m_msk1 = '0;
         m_irq = '0; m_cmdgo = 1'b0; m_datago = 1'b0;
      end else begin
         m_clr = '0;
         m_irq[0] = |(m_sts & m_msk0[21:0]);
         m_irq[1] = |(m_sts & m_msk1[21:0]);
         m_cmdgo = 1'b0;
         m_datago = 1'b0;
         if (bus_sel && bus_wr) begin
            case (int'(bus_addr[11:2]))
               0:  m_pwr = bus_wdata[7:0];
               1:  m_clk = bus_wdata[7:0];
               2:  m_arg = bus_wdata;
               3:  begin m_cmd = bus_wdata & ~32'h400; m_cmdgo = bus_wdata[10]; end
               9:  m_dtmr = bus_wdata;
               10: m_dlen = bus_wdata[15:0];
               11: begin m_dctl = bus_wdata[7:0]; m_datago = bus_wdata[0]; end
               14: m_clr = bus_wdata[21:0] & 22'h0007FF;
               15: m_msk0 = bus_wdata;
               16: m_msk1 = bus_wdata;
               default: ;
            endcase
         end
         m_sts = (m_sts & ~m_clr) | sts_set;
      end
      // The bench plays the FIFO.
      if (fifo_pop && fq.size() != 0) void'(fq.pop_front());
      if (fifo_push) fq.push_back(fifo_wdata);
      fifo_empty = (fq.size() == 0);
      fifo_rdata = fifo_empty ? 32'hDEAD_0000 : fq[0];
   end

   // Registered outputs compared every cycle.
   always @(negedge clk) begin
      if (cmp_en) begin
         chk(irq === m_irq, "R6 irq", 32'(irq), 32'(m_irq));
         chk(cmd_go === m_cmdgo, "R3 cmd_go", 32'(cmd_go), 32'(m_cmdgo));
         chk(data_go === m_datago, "R3 data_go", 32'(data_go), 32'(m_datago));
         chk(cmd_q === m_cmd, "R3 cmd_q", cmd_q, m_cmd);
         chk(pwr_q === m_pwr, "R2 pwr_q", 32'(pwr_q), 32'(m_pwr));
         chk(clkdiv_q === m_clk, "R2 clkdiv_q", 32'(clkdiv_q), 32'(m_clk));
         chk(arg_q === m_arg, "R2 arg_q", arg_q, m_arg);
         chk(dtmr_q === m_dtmr, "R2 dtmr_q", dtmr_q, m_dtmr);
         chk(dlen_q === m_dlen, "R2 dlen_q", 32'(dlen_q), 32'(m_dlen));
         chk(dctl_q === m_dctl, "R2 dctl_q", 32'(dctl_q), 32'(m_dctl));
      end
   end

   function automatic logic [31:0] exp_rd(input logic [11:0] a, output string tag);
      int w;
      w = int'(a[11:2]);
      tag = "R10 unmapped";
      exp_rd = '0;
      if (w >= 32 && w <= 47) begin
         tag = "R7 fifo read";
         exp_rd = (fq.size() != 0) ? fq[0] : 32'h0;
      end else if (w >= 1016) begin
         tag = "R9 id";
         exp_rd = 32'(id_tab[w - 1016]);
      end else if (w >= 5 && w <= 8) begin
         tag = "R11 response";
         exp_rd = resp_in[32*(w-5) +: 32];
      end else begin
         case (w)
            0:  begin tag = "R2 power";  exp_rd = 32'(m_pwr); end
            1:  begin tag = "R2 clock";  exp_rd = 32'(m_clk); end
            2:  begin tag = "R2 arg";    exp_rd = m_arg; end
            3:  begin tag = "R3 cmd";    exp_rd = m_cmd; end
            4:  begin tag = "R11 rcmd";  exp_rd = resp_cmd_in; end
            9:  begin tag = "R2 dtimer"; exp_rd = m_dtmr; end
            10: begin tag = "R2 dlen";   exp_rd = 32'(m_dlen); end
            11: begin tag = "R2 dctl";   exp_rd = 32'(m_dctl); end
            12: begin tag = "R11 dcnt";  exp_rd = 32'(byte_cnt); end
            13: begin tag = "R4 status"; exp_rd = 32'(m_sts); end
            14: begin tag = "R5 clear read"; exp_rd = '0; end
            15: begin tag = "R6 mask0";  exp_rd = m_msk0; end
            16: begin tag = "R6 mask1";  exp_rd = m_msk1; end
            18: begin tag = "R11 fcnt";  exp_rd = (32'(byte_cnt) + 32'd3) >> 2; end
            default: ;
         endcase
      end
   endfunction

   task automatic rd(input logic [11:0] a);
      logic [31:0] e;
      string tag;
      bit ep;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0; sts_set = '0;
      #2;
      e = exp_rd(a, tag);
      chk(bus_rdata === e, tag, bus_rdata, e);
      ep = (a[11:2] >= 10'd32 && a[11:2] <= 10'd47) && fq.size() != 0;
      chk(fifo_pop === ep, "R7 pop", 32'(fifo_pop), 32'(ep));
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [21:0] s);
      bit ep;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sts_set = s;
      #2;
      ep = (a[11:2] >= 10'd32 && a[11:2] <= 10'd47) && byte_cnt != 16'd0;
      chk(fifo_push === ep, "R8 push", 32'(fifo_push), 32'(ep));
      if (ep) chk(fifo_wdata === d, "R8 push data", fifo_wdata, d);
   endtask

   task automatic idle(input int n, input logic [21:0] s);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_sel = 1'b0; bus_wr = 1'b0; sts_set = (i == 0) ? s : 22'h0;
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk(irq === 2'b00, "R1 irq", 32'(irq), 0);
      chk(cmd_q === 32'h0 && arg_q === 32'h0, "R1 cmd/arg", cmd_q | arg_q, 0);
      chk(pwr_q === 8'h0 && dlen_q === 16'h0 && dctl_q === 8'h0, "R1 narrow",
          32'(pwr_q) | 32'(dlen_q) | 32'(dctl_q), 0);
      chk(cmd_go === 1'b0 && data_go === 1'b0, "R1 pulses", 32'({cmd_go, data_go}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      rd(12'h034); rd(12'h03C); rd(12'h040); rd(12'h00C);

      // R2: widths of stored registers
      wr(12'h000, 32'hFFFF_FFA5, 0); wr(12'h004, 32'h1234_5678, 0);
      wr(12'h008, 32'hCAFE_F00D, 0); wr(12'h024, 32'h0BAD_BEEF, 0);
      wr(12'h028, 32'hABCD_9876, 0); wr(12'h02C, 32'hFFFF_FF0E, 0);
      rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h024); rd(12'h028); rd(12'h02C);

      // R3: start pulses and command start bit
      wr(12'h00C, 32'h0000_0452, 0); idle(2, 0); rd(12'h00C);
      wr(12'h00C, 32'h0000_0052, 0); idle(1, 0);
      wr(12'h02C, 32'h0000_0003, 0); wr(12'h02C, 32'h0000_0002, 0); idle(2, 0);

      // R4/R6: sticky status and masked interrupt lines
      wr(12'h03C, 32'h0000_0041, 0); wr(12'h040, 32'h0001_0000, 0);
      idle(3, 22'h000040); rd(12'h034);
      idle(2, 22'h010000); rd(12'h034); rd(12'h03C); rd(12'h040);
      // R4: clear and set of the same bit in one cycle, set wins
      wr(12'h038, 32'h0000_0040, 22'h000040); idle(2, 0); rd(12'h034);
      // R5: clear all, upper bits survive
      idle(1, 22'h200008);
      wr(12'h038, 32'hFFFF_FFFF, 0); idle(2, 0); rd(12'h034); rd(12'h038);
      wr(12'h03C, 32'h0020_0000, 0); idle(3, 0);
      wr(12'h03C, 32'h0, 0); wr(12'h040, 32'h0, 0); idle(3, 0);

      // R8: push refused with zero count, then accepted
      byte_cnt = 16'd0;
      wr(12'h080, 32'h1111_1111, 0);
      byte_cnt = 16'd13;
      wr(12'h080, 32'hAAAA_0001, 0); wr(12'h0BC, 32'hAAAA_0002, 0);
      wr(12'h09C, 32'hAAAA_0003, 0); idle(1, 0);
      // R7: pop across the window, then empty
      rd(12'h0A4); rd(12'h080); rd(12'h0BC); rd(12'h090); rd(12'h084);

      // R9: identification bytes
      for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i));

      // R11: engine-reported values and rounded word count
      rd(12'h010);
      for (int i = 0; i < 4; i++) rd(12'h014 + 12'(4 * i));
      foreach (id_tab[i]) begin
         byte_cnt = (i == 0) ? 16'd0 : (i == 1) ? 16'd1 : (i == 2) ? 16'd4 :
                    (i == 3) ? 16'd5 : 16'hFFFF;
         rd(12'h030); rd(12'h048);
      end

      // R10: unmapped and read-only offsets
      rd(12'h044); rd(12'h04C); rd(12'h07C); rd(12'h0C0); rd(12'hFDC);
      wr(12'h044, 32'hFFFF_FFFF, 0); wr(12'h010, 32'hFFFF_FFFF, 0);
      wr(12'h034, 32'hFFFF_FFFF, 0); wr(12'h0C0, 32'hFFFF_FFFF, 0);
      wr(12'hFE0, 32'hFFFF_FFFF, 0); idle(2, 0);
      rd(12'h034); rd(12'h000); rd(12'h03C); rd(12'h040); rd(12'h010);
      idle(3, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule